// File: doc/BRIEF.md
# Slave-Mode Bus Requester

This controller sits beside the memory-access engine of a processor that runs as a bus slave on a shared external bus. Out of reset it does not own the bus, and it leaves every address and control pin floating. Whenever the local side needs an access, including the very first fetch after reset, the controller must first win the bus from the master through a request/grant handshake.

It pulls an active-low request line low and waits for the master's active-low grant. The grant counts only after it has been sampled low on two rising edges in a row. The controller then switches on the output enables for the address and control pins, with the control pins held at their inactive level, and on the next edge it pulses a start strobe to the access engine.

When the engine reports that the cycle is done, the controller raises the request line to hand the bus back. For a DRAM-type access it first waits for a separate signal that the precharge has finished. One edge after the request line rises, the pins are floated again. A refresh-enable input exists for the master-mode configuration and has no effect here: the controller never asks for a refresh.

Top module: `slave_bus_requester`

## Requirements
- R1: While reset is applied and after it is released, `breq_n` is 1, `addr_oe`, `ctl_oe`, `ctl_hold_neg` and `cyc_start` are 0, and the controller is in the released state.
- R2: The first access after reset drives no pin until the full handshake has completed. The handshake is: request low, then the grant qualified.
- R3: `breq_n` changes only at rising clock edges. It goes to 0 at the edge that samples `acc_req`=1 while the controller is released and idle.
- R4: While requesting, the grant (`bgnt_n`=0) is qualified at the second consecutive rising edge that samples it low. Samples taken before the request was raised do not count.
- R5: At the edge that qualifies the grant, `addr_oe` and `ctl_oe` both go to 1 and `ctl_hold_neg` goes to 1, so the control pins are driven at their inactive level.
- R6: `cyc_start` is 1 for exactly one clock, starting at the edge after the enables first rose. In that same cycle `ctl_hold_neg` is 0.
- R7: For a non-DRAM access (`dram_acc`=0 sampled with the request), `breq_n` stays 0 until the edge that samples `cyc_done`=1 during the cycle. At that edge `breq_n` goes to 1, while the enables stay 1 with `ctl_hold_neg`=1.
- R8: For a DRAM access (`dram_acc`=1), `cyc_done` does not release the bus. `breq_n` goes to 1 only at the edge that later samples `pchg_done`=1.
- R9: One edge after `breq_n` rises, `addr_oe`, `ctl_oe` and `ctl_hold_neg` return to 0.
- R10: `refresh_en` has no effect: `rfsh_req` stays 0 and the handshake timing does not change whichever value it has.
- R11: If the grant goes high during qualification, the count starts again. `breq_n` stays 0 and the enables stay 0 until two consecutive low samples are seen.
- R12: `cyc_done` or `pchg_done` sampled outside the phase that waits for it has no effect, and `acc_req` is not acted on until the controller is back in the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Local request for a bus access |
| dram_acc | input | 1 | Access is DRAM-type; sampled with `acc_req` |
| bgnt_n | input | 1 | Bus grant from the master, active low |
| cyc_done | input | 1 | Access engine reports that the data cycle has ended |
| pchg_done | input | 1 | Access engine reports that DRAM precharge has finished |
| refresh_en | input | 1 | Refresh enable setting; ignored in this mode |
| breq_n | output | 1 | Bus request to the master, active low |
| addr_oe | output | 1 | Output enable for the address pins |
| ctl_oe | output | 1 | Output enable for the control pins |
| ctl_hold_neg | output | 1 | Force the driven control pins to their inactive level |
| cyc_start | output | 1 | One-clock strobe that starts the access engine |
| rfsh_req | output | 1 | Refresh request; never asserted |

## Verification
The bench drives a grant that is already low before the request is raised. A design that counted those early samples would turn on its pins one edge too soon. It also sends a grant that is low for one cycle and then high. A design that did not restart its count would drive the bus on a single low sample. DRAM accesses get a stray precharge-done pulse before the cycle has ended, and the access is then left waiting for a long precharge. A design that released on `cyc_done` alone, or acted on the stray pulse, would raise the request early. Other stimulus covers done pulses and requests that arrive while the controller is idle or busy, and refresh-enable toggling. Each of these would show up as an extra start strobe, a wrong access type, or a change in timing.

// File: rtl/slave_bus_requester.sv
module slave_bus_requester #(
  parameter int GNT_QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic dram_acc,
  input  logic bgnt_n,
  input  logic cyc_done,
  input  logic pchg_done,
  input  logic refresh_en,
  output logic breq_n,
  output logic addr_oe,
  output logic ctl_oe,
  output logic ctl_hold_neg,
  output logic cyc_start,
  output logic rfsh_req
);

  localparam int CW = $clog2(GNT_QUAL + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_DRIVE, S_START, S_BUSY, S_PCHG, S_REL
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] qcnt, qcnt_nx;
  logic dram_q;

  wire gnt_last = !bgnt_n && (qcnt == CW'(GNT_QUAL - 1));

  always_comb begin
    st_nx = st;
    qcnt_nx = '0;
    case (st)
      S_IDLE:  if (acc_req) st_nx = S_REQ;
      S_REQ: begin
        if (gnt_last) st_nx = S_DRIVE;
        else if (!bgnt_n) qcnt_nx = qcnt + 1'b1;
      end
      S_DRIVE: st_nx = S_START;
      S_START: st_nx = S_BUSY;
      S_BUSY:  if (cyc_done) st_nx = dram_q ? S_PCHG : S_REL;
      S_PCHG:  if (pchg_done) st_nx = S_REL;
      S_REL:   st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qcnt <= '0;
      dram_q <= 1'b0;
    end else begin
      st <= st_nx;
      qcnt <= qcnt_nx;
      if (st == S_IDLE && acc_req) dram_q <= dram_acc;
    end
  end

  assign breq_n       = (st == S_IDLE) || (st == S_REL);
  assign addr_oe      = (st != S_IDLE) && (st != S_REQ);
  assign ctl_oe       = addr_oe;
  assign ctl_hold_neg = (st == S_DRIVE) || (st == S_REL);
  assign cyc_start    = (st == S_START);
  assign rfsh_req     = refresh_en & 1'b0;

endmodule

// File: rtl/slave_bus_requester_chk.sv
module slave_bus_requester_chk (
  input logic clk,
  input logic rst_n,
  input logic bgnt_n,
  input logic breq_n,
  input logic addr_oe,
  input logic ctl_oe,
  input logic ctl_hold_neg,
  input logic cyc_start
);

  p_oe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe == ctl_oe);

  p_oe_after_two_grants_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> (!$past(bgnt_n) && !$past(bgnt_n, 2) && ctl_hold_neg));

  p_oe_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> !breq_n && !$past(breq_n));

  p_start_follows_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> $past(addr_oe) && $past(ctl_hold_neg) && !ctl_hold_neg);

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  p_float_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breq_n) |=> !addr_oe && !ctl_oe && !ctl_hold_neg);

  p_release_keeps_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && breq_n) |-> ctl_hold_neg);

endmodule

bind slave_bus_requester slave_bus_requester_chk u_chk (.*);

// File: tb/slave_bus_requester_bench.sv
module slave_bus_requester_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 0, dram_acc = 0, bgnt_n = 1, cyc_done = 0, pchg_done = 0, refresh_en = 0;
  logic breq_n, addr_oe, ctl_oe, ctl_hold_neg, cyc_start, rfsh_req;

  always #2.5 clk = ~clk;

  slave_bus_requester u_slave_bus_requester (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string scen = "R1";

  // reference model: phase names as strings, grant streak counter
  string ph = "idle";
  int streak = 0;
  bit is_dram = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = "idle"; streak = 0; is_dram = 0;
    end else if (ph == "idle") begin
      if (acc_req) begin ph = "wait"; is_dram = dram_acc; streak = 0; end
    end else if (ph == "wait") begin
      streak = bgnt_n ? 0 : streak + 1;
      if (streak >= 2) begin ph = "neg"; streak = 0; end
    end else if (ph == "neg") ph = "go";
    else if (ph == "go") ph = "data";
    else if (ph == "data") begin
      if (cyc_done) ph = is_dram ? "pre" : "free";
    end else if (ph == "pre") begin
      if (pchg_done) ph = "free";
    end else if (ph == "free") ph = "idle";
  end

  task automatic cmp(string tag, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (%s, phase %s) %s: actual %b expected %b", tag, scen, ph, what, got, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    logic e_req, e_oe, e_neg, e_st;
    string t;
    e_req = !(ph == "idle" || ph == "free");
    e_oe  = !(ph == "idle" || ph == "wait");
    e_neg = (ph == "neg" || ph == "free");
    e_st  = (ph == "go");
    if (!rst_n || ph == "idle") t = "R1";
    else if (ph == "wait") t = "R4";
    else if (ph == "neg") t = "R5";
    else if (ph == "go") t = "R6";
    else if (ph == "data") t = "R7";
    else if (ph == "pre") t = "R8";
    else t = "R9";
    cmp(t == "R1" ? "R3" : t, "breq_n", breq_n, !e_req);
    cmp(t, "addr_oe", addr_oe, e_oe);
    cmp(t, "ctl_oe", ctl_oe, e_oe);
    cmp(t, "ctl_hold_neg", ctl_hold_neg, e_neg);
    cmp("R6", "cyc_start", cyc_start, e_st);
    cmp("R10", "rfsh_req", rfsh_req, 1'b0);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(bit d);
    acc_req = 1; dram_acc = d; tick(1); acc_req = 0; dram_acc = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // R2: first access after reset, grant already low before request
    scen = "R2";
    bgnt_n = 0; tick(2);
    pulse_req(0); tick(6);
    cyc_done = 1; tick(1); cyc_done = 0; tick(3);
    // R11: grant glitches during qualification
    scen = "R11";
    bgnt_n = 1; pulse_req(0); tick(2);
    bgnt_n = 0; tick(1); bgnt_n = 1; tick(2);
    bgnt_n = 0; tick(1); bgnt_n = 1; tick(1);
    bgnt_n = 0; tick(6);
    cyc_done = 1; tick(1); cyc_done = 0; tick(3);
    // R8: DRAM access, stray precharge-done before cycle end, long precharge
    scen = "R8";
    pulse_req(1); tick(4);
    pchg_done = 1; tick(1); pchg_done = 0; tick(2);
    cyc_done = 1; tick(1); cyc_done = 0; tick(7);
    pchg_done = 1; tick(1); pchg_done = 0; tick(3);
    // R12: done pulses while idle, request while busy
    scen = "R12";
    cyc_done = 1; pchg_done = 1; tick(2); cyc_done = 0; pchg_done = 0; tick(1);
    pulse_req(0); tick(4);
    acc_req = 1; dram_acc = 1; tick(2); acc_req = 0; dram_acc = 0; tick(1);
    cyc_done = 1; tick(1); cyc_done = 0; tick(3);
    // R10: refresh enable set, back-to-back accesses with request held
    scen = "R10";
    refresh_en = 1; acc_req = 1; tick(6);
    cyc_done = 1; tick(1); cyc_done = 0; tick(6);
    cyc_done = 1; tick(1); cyc_done = 0; acc_req = 0; tick(3);
    refresh_en = 0;
    // R1: reset in the middle of an access
    scen = "R1";
    pulse_req(0); tick(4);
    rst_n = 0; tick(2); rst_n = 1; tick(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule